// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses of one SDRAM read or write burst, one address per clock. A start strobe captures a starting column, a burst-length code and a wrap-order bit. From the next cycle on, the block drives the addressed column together with a valid flag. A last flag marks the final beat of a burst of fixed length. A stop request cuts a burst short. A new start replaces the current burst at once, on any clock.

Fixed bursts of 2, 4 or 8 beats stay inside the aligned block of that size that holds the starting column. Within that block they run in one of two orders. Sequential order counts the low bits upward and wraps them. Interleaved order XORs the low bits with the beat index. In full-page mode the address steps through every column of the row, wraps from the top column back to zero, and keeps going until a stop or a new start arrives. The column width is the parameter `COL_W`, which defaults to 10 bits (1024 columns). Set it to 11 for 2048 columns.

Top module: `sdram_col_burst`

## Requirements
- R1: While `rstN` is low at a clock edge, the block goes idle, and after that edge `validOut` and `lastOut` are 0.
- R2: When `startIn` is high at a clock edge, then in the following cycle `validOut` is 1 and `colOut` equals the sampled `startCol`.
- R3: `lenCode` values 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. Any value with bit 2 set selects full page. Without stop or restart, a fixed burst keeps `validOut` high for exactly that many cycles and then drops it.
- R4: In sequential order (`interleave`=0) with a fixed length BL, beat k presents the start column with its low log2(BL) bits replaced by (low bits + k) mod BL. The upper bits stay unchanged.
- R5: In interleaved order (`interleave`=1) with a fixed length BL, beat k presents the start column XOR k, where k ranges over 0..BL-1.
- R6: In full-page mode, beat k presents (start + k) mod 2^COL_W regardless of `interleave`, and the burst does not end by itself.
- R7: `lastOut` is 1 exactly in the cycle that presents the final beat of a fixed-length burst. It is never 1 in full-page mode, and never 1 while `validOut` is 0.
- R8: When `stopIn` is high at a clock edge and `startIn` is low, `validOut` is 0 from the next cycle on. A stop while idle has no effect.
- R9: A start during a burst replaces it in the next cycle. A start and a stop in the same cycle act as a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| startIn | input | 1 | Begin a new burst this cycle |
| startCol | input | COL_W | Starting column, sampled with startIn |
| lenCode | input | 3 | Burst length: 0..3 = 1/2/4/8 beats, bit 2 set = full page |
| interleave | input | 1 | Wrap order: 0 sequential, 1 interleaved |
| stopIn | input | 1 | End the current burst |
| colOut | output | COL_W | Column address of the current beat |
| validOut | output | 1 | colOut holds a beat |
| lastOut | output | 1 | Final beat of a fixed-length burst |

## Verification
Directed bursts use starting columns whose low bits are non-zero and whose upper bits are mixed. These runs separate the sequential wrap from a plain increment, and they separate the interleaved XOR from the sequential order. A full-page run that begins just below the top column shows the wrap to zero, and it shows that the order bit is ignored there. Stops, restarts, and a start and stop in the same cycle are applied at chosen beats. Random traffic then mixes every length and order with random stops and restarts, and each cycle is compared against a reference model in the bench.

// File: rtl/col_burst_pkg.sv
package col_burst_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new start column, clear the beat offset
    logic step;   // advance to the next beat
  } seqStrobe_t;

  // Index of the final beat for a fixed length selector (0..3 -> 1/2/4/8 beats)
  function automatic logic [2:0] finalBeatOf(input logic [1:0] lenSel);
    case (lenSel)
      2'd0:    finalBeatOf = 3'd0;
      2'd1:    finalBeatOf = 3'd1;
      2'd2:    finalBeatOf = 3'd3;
      default: finalBeatOf = 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/col_burst_ctrl.sv
module col_burst_ctrl
  import col_burst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic [2:0] lenCode,
  input  logic       interleave,
  input  logic       stopIn,
  output seqStrobe_t strobe,
  output logic [1:0] lenSel,
  output logic       fullPage,
  output logic       ilMode,
  output logic       validOut,
  output logic       lastOut
);

  logic       validQ, lastQ, fullQ, ilQ;
  logic [1:0] lenQ;
  logic [2:0] beatQ;
  logic [2:0] finalBeat;
  logic       continueBurst;

  assign finalBeat     = finalBeatOf(lenQ);
  assign continueBurst = validQ & ~stopIn & ~startIn & (fullQ | (beatQ != finalBeat));

  assign strobe.load = startIn;
  assign strobe.step = continueBurst;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      lastQ  <= 1'b0;
      fullQ  <= 1'b0;
      ilQ    <= 1'b0;
      lenQ   <= 2'd0;
      beatQ  <= 3'd0;
    end else if (startIn) begin
      validQ <= 1'b1;
      beatQ  <= 3'd0;
      lenQ   <= lenCode[1:0];
      fullQ  <= lenCode[2];
      ilQ    <= interleave & ~lenCode[2];
      lastQ  <= ~lenCode[2] & (lenCode[1:0] == 2'd0);
    end else if (continueBurst) begin
      beatQ  <= beatQ + 3'd1;
      lastQ  <= ~fullQ & ((beatQ + 3'd1) == finalBeat);
    end else begin
      validQ <= 1'b0;
      lastQ  <= 1'b0;
    end
  end

  assign lenSel   = lenQ;
  assign fullPage = fullQ;
  assign ilMode   = ilQ;
  assign validOut = validQ;
  assign lastOut  = lastQ;

  // R8: a stop without a start ends the burst on the next cycle
  a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rstN)
    (stopIn && !startIn) |=> !validOut);

  // R9: a start always yields a valid beat next cycle, even with a stop
  a_r9_start_wins: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> validOut);

  // R7: no last flag in full-page mode
  a_r7_no_last_full: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && fullPage) |-> !lastOut);

  // R7: last flag only on a valid beat
  a_r7_last_valid: assert property (@(posedge clk) disable iff (!rstN)
    lastOut |-> validOut);

  // R3: after the final beat the burst is over unless restarted
  a_r3_last_then_idle: assert property (@(posedge clk) disable iff (!rstN)
    (lastOut && !startIn) |=> !validOut);

endmodule

// File: rtl/col_burst_path.sv
module col_burst_path
  import col_burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [COL_W-1:0] startCol,
  input  logic [1:0]       lenSel,
  input  logic             fullPage,
  input  logic             ilMode,
  output logic [COL_W-1:0] colOut
);

  localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

  logic [COL_W-1:0] baseQ, offQ;
  logic [COL_W-1:0] wrapMask;
  logic [COL_W-1:0] seqAddr, ilAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      offQ  <= '0;
    end else if (strobe.load) begin
      baseQ <= startCol;
      offQ  <= '0;
    end else if (strobe.step) begin
      offQ  <= offQ + COL_W'(1);
    end
  end

  always_comb begin
    if (fullPage) wrapMask = ALL_ONES;
    else          wrapMask = COL_W'(finalBeatOf(lenSel));
  end

  assign seqAddr = (baseQ & ~wrapMask) | ((baseQ + offQ) & wrapMask);
  assign ilAddr  = baseQ ^ (offQ & wrapMask);
  assign colOut  = ilMode ? ilAddr : seqAddr;

  // R2: the first beat presents the captured start column
  a_r2_load_col: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (colOut == $past(startCol)));

  // R4: within a fixed burst the bits above the wrap block do not move
  a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !fullPage) |=> ((colOut & ~wrapMask) == $past(colOut & ~wrapMask)));

  // R6: full page steps by one column with wrap
  a_r6_page_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && fullPage) |=> (colOut == $past(colOut) + COL_W'(1)));

endmodule

// File: rtl/sdram_col_burst.sv
module sdram_col_burst
  import col_burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             interleave,
  input  logic             stopIn,
  output logic [COL_W-1:0] colOut,
  output logic             validOut,
  output logic             lastOut
);

  seqStrobe_t strobe;
  logic [1:0] lenSel;
  logic       fullPage;
  logic       ilMode;

  col_burst_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startIn    (startIn),
    .lenCode    (lenCode),
    .interleave (interleave),
    .stopIn     (stopIn),
    .strobe     (strobe),
    .lenSel     (lenSel),
    .fullPage   (fullPage),
    .ilMode     (ilMode),
    .validOut   (validOut),
    .lastOut    (lastOut)
  );

  col_burst_path #(.COL_W(COL_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .startCol (startCol),
    .lenSel   (lenSel),
    .fullPage (fullPage),
    .ilMode   (ilMode),
    .colOut   (colOut)
  );

endmodule

// File: tb/tb_sdram_col_burst.sv
`timescale 1ns/1ps
module tb_sdram_col_burst;

  localparam int COLW = 10;

  logic            clk = 1'b0;
  logic            rstN;
  logic            startIn;
  logic [COLW-1:0] startCol;
  logic [2:0]      lenCode;
  logic            interleave;
  logic            stopIn;
  logic [COLW-1:0] colOut;
  logic            validOut;
  logic            lastOut;

  sdram_col_burst #(.COL_W(COLW)) dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .startCol(startCol),
    .lenCode(lenCode), .interleave(interleave), .stopIn(stopIn),
    .colOut(colOut), .validOut(validOut), .lastOut(lastOut)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  bit            refV;
  int            refK;
  int            refBase;
  logic [2:0]    refCode;
  bit            refIl;

  function automatic int burstLen(input logic [2:0] code);
    return code[2] ? 0 : (1 << code[1:0]);
  endfunction

  function automatic int expCol(input int base, input logic [2:0] code, input bit il, input int k);
    int bl, m;
    if (code[2]) return (base + k) % (1 << COLW);
    bl = burstLen(code);
    m  = bl - 1;
    if (il) return base ^ k;
    return (base & ~m & ((1 << COLW) - 1)) | ((base + k) & m);
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic tick(input bit s, input int col, input logic [2:0] code,
                      input bit il, input bit st, input string tag);
    bit expLast;
    string colTag;
    startIn = s; startCol = COLW'(col); lenCode = code; interleave = il; stopIn = st;
    @(posedge clk);
    if (s) begin
      refV = 1; refK = 0; refBase = col; refCode = code; refIl = il;
    end else if (st) begin
      refV = 0;
    end else if (refV) begin
      if (!refCode[2] && refK == burstLen(refCode) - 1) refV = 0;
      else refK++;
    end
    @(negedge clk);
    expLast = refV && !refCode[2] && (refK == burstLen(refCode) - 1);
    check(tag, "valid", int'(validOut), int'(refV));
    check("R7", "last", int'(lastOut), int'(expLast));
    if (refV) begin
      colTag = refCode[2] ? "R6" : (refIl ? "R5" : "R4");
      check(colTag, "col", int'(colOut), expCol(refBase, refCode, refIl, refK));
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(0, 0, 3'd0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 0; startIn = 0; startCol = '0; lenCode = 0; interleave = 0; stopIn = 0;
    refV = 0; refK = 0; refBase = 0; refCode = 0; refIl = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "valid after reset", int'(validOut), 0);
    check("R1", "last after reset", int'(lastOut), 0);
    rstN = 1;

    // R2: first beat is the start column
    tick(1, 'h1F5, 3'd3, 0, 0, "R2");
    check("R2", "first col", int'(colOut), 'h1F5);
    idle(9, "R3");

    // R3/R4/R5: every fixed length, both orders, unaligned start
    for (int c = 0; c < 4; c++) begin
      for (int o = 0; o < 2; o++) begin
        tick(1, 'h2C3 + c, 3'(c), o[0], 0, "R3");
        idle(9, "R3");
      end
    end

    // R6: full page near the top with interleave set, wraps to zero
    tick(1, 1021, 3'd7, 1, 0, "R6");
    idle(6, "R6");
    check("R6", "wrapped col", int'(colOut), 3);
    // R8: stop ends it, then stop while idle
    tick(0, 0, 3'd0, 0, 1, "R8");
    tick(0, 0, 3'd0, 0, 1, "R8");
    idle(2, "R8");
    check("R8", "idle after stop", int'(validOut), 0);

    // R9: restart mid-burst, then start together with stop
    tick(1, 'h155, 3'd3, 0, 0, "R9");
    idle(3, "R9");
    tick(1, 'h0AA, 3'd2, 1, 0, "R9");
    check("R9", "restart col", int'(colOut), 'h0AA);
    idle(1, "R9");
    tick(1, 'h3FE, 3'd1, 0, 1, "R9");
    check("R9", "start beats stop", int'(validOut), 1);
    idle(4, "R9");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit s, st;
      logic [2:0] code;
      r = $urandom_range(0, 5);
      code = (r == 4) ? 3'd4 : (r == 5) ? 3'd7 : 3'(r);
      s  = refV ? ($urandom_range(0, 9) == 0) : ($urandom_range(0, 2) == 0);
      st = ($urandom_range(0, 15) == 0);
      tick(s, int'($urandom_range(0, (1 << COLW) - 1)), code, $urandom_range(0, 1) != 0, st,
           st ? "R8" : "R3");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule